// File: doc/BRIEF.md
# I2C Start/Stop Hold Qualifier

This block sits beside an I2C slave and decides when a START or a STOP on the bus has lasted long enough to count. It watches synchronized SDA and SCL inputs. An SDA edge seen while SCL is high opens a candidate condition. The candidate is accepted only if SCL stays high and SDA keeps its new level for a programmed number of sample ticks. One sample tick lasts two system clocks.

An 8-bit setup register sets the required hold. Its top bit is an enable. When the enable is clear, one sample is enough. When it is set, the low seven bits plus one give the sample count, from 1 up to 128. The setting is chosen so that the hold time in nanoseconds meets the bus specification at the system clock in use. For example, at a 40 MHz clock the value 8Bh asks for 12 samples, which is 600 ns.

A qualified condition raises a one-clock pulse on its own output. A bus-busy flag follows the accepted STOPs and STARTs.

Top module: `i2c_cond_qual`

## Requirements
- R1: After reset, startDet, stopDet and busBusy are 0 and the setup register holds 00h, so a condition needs one sample.
- R2: SDA falling from 1 to 0 while SCL is 1, then held, gives one startDet pulse exactly one system clock wide.
- R3: SDA rising from 0 to 1 while SCL is 1, then held, gives one stopDet pulse exactly one system clock wide.
- R4: With setup bit 7 = 1, the required hold is N = bits[6:0] + 1 samples. The pulse first shows after rising edge 2N or 2N+1, counting from the edge that first samples the new SDA level as edge 1 (80h gives N=1, 8Bh gives N=12, FFh gives N=128).
- R5: With setup bit 7 = 0, N = 1 whatever bits[6:0] hold.
- R6: If SCL goes low before the count completes, the candidate is discarded and no pulse is produced.
- R7: If SDA returns to its old level before the count completes, the candidate is discarded, and neither startDet nor stopDet pulses.
- R8: SDA transitions while SCL is low produce no pulse and leave busBusy unchanged.
- R9: busBusy becomes 1 together with a startDet pulse, stays 1 through a repeated START, and becomes 0 together with a stopDet pulse.
- R10: A setup write made while a candidate is being counted leaves that candidate's N unchanged. The next candidate uses the new value.
- R11: startDet and stopDet are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Setup register write strobe |
| cfgWrData | input | 8 | Setup value: bit 7 enable, bits 6:0 count minus one |
| sdaIn | input | 1 | Synchronized SDA level |
| sclIn | input | 1 | Synchronized SCL level |
| startDet | output | 1 | One-clock pulse on a qualified START |
| stopDet | output | 1 | One-clock pulse on a qualified STOP |
| busBusy | output | 1 | Set by qualified START, cleared by qualified STOP |

## Verification
A wrong hold count or a target loaded from the wrong place shows at the ports as a pulse latency outside the two-cycle window of R4, within 2N+1 clocks of the SDA edge. A counter that is not cleared on an abort shows as a pulse that should never come, or one that comes early, on the next candidate. A stale busy state or a wrongly latched target from a mid-count write shows within one further condition, which is why each scenario ends with the opposite condition and its own latency check.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_HOLDSTART = 2'd1,
    ST_HOLDSTOP  = 2'd2
  } condState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTarget;
    logic clearCnt;
    logic incCnt;
    logic fireStart;
    logic fireStop;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic startEdge;
    logic stopEdge;
    logic tick;
    logic hit;
    logic sdaNow;
    logic sclNow;
  } dpStatus_t;

endpackage

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int TICK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             sdaIn,
  input  logic             sclIn,
  input  ctrlStrobe_t      strb,
  output dpStatus_t        stat,
  output logic             startDet,
  output logic             stopDet,
  output logic             busBusy
);

  localparam int FIELD_W = CFG_W - 1;
  localparam int CNT_W   = FIELD_W + 1;
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CFG_W-1:0] cfgQ;
  logic             sdaPrevQ;
  logic [DIV_W-1:0] divQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] targetQ;
  logic [CNT_W-1:0] targetNew;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sdaPrevQ <= 1'b1;
    else sdaPrevQ <= sdaIn;
  end

  // free-running sample tick divider
  always_ff @(posedge clk) begin
    if (!rstN) divQ <= '0;
    else if (divQ == DIV_W'(TICK_DIV - 1)) divQ <= '0;
    else divQ <= divQ + 1'b1;
  end
  assign tick = (divQ == DIV_W'(TICK_DIV - 1));

  always_comb begin
    if (cfgQ[CFG_W-1]) targetNew = {1'b0, cfgQ[FIELD_W-1:0]} + CNT_W'(1);
    else targetNew = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) targetQ <= CNT_W'(1);
    else if (strb.loadTarget) targetQ <= targetNew;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (strb.clearCnt) cntQ <= '0;
    else if (strb.incCnt) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startDet <= 1'b0;
      stopDet  <= 1'b0;
      busBusy  <= 1'b0;
    end else begin
      startDet <= strb.fireStart;
      stopDet  <= strb.fireStop;
      if (strb.fireStart) busBusy <= 1'b1;
      else if (strb.fireStop) busBusy <= 1'b0;
    end
  end

  assign stat.startEdge = sdaPrevQ & ~sdaIn & sclIn;
  assign stat.stopEdge  = ~sdaPrevQ & sdaIn & sclIn;
  assign stat.tick      = tick;
  assign stat.hit       = ((cntQ + CNT_W'(1)) == targetQ);
  assign stat.sdaNow    = sdaIn;
  assign stat.sclNow    = sclIn;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < targetQ);

  // R11
  det_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet));

  // R2
  start_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !startDet);

  // R3
  stop_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !stopDet);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |-> busBusy);

  // R9
  busy_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |-> !busBusy);

  // R6
  scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |-> $past(sclIn));

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb
);

  condState_e stateQ, stateD;
  logic       holdOk;

  always_comb begin
    case (stateQ)
      ST_HOLDSTART: holdOk = stat.sclNow & ~stat.sdaNow;
      ST_HOLDSTOP:  holdOk = stat.sclNow & stat.sdaNow;
      default:      holdOk = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (stat.startEdge) begin
          strb.loadTarget = 1'b1;
          strb.clearCnt   = 1'b1;
          stateD          = ST_HOLDSTART;
        end else if (stat.stopEdge) begin
          strb.loadTarget = 1'b1;
          strb.clearCnt   = 1'b1;
          stateD          = ST_HOLDSTOP;
        end
      end
      ST_HOLDSTART, ST_HOLDSTOP: begin
        if (!holdOk) begin
          strb.clearCnt = 1'b1;
          stateD        = ST_IDLE;
        end else if (stat.tick) begin
          if (stat.hit) begin
            strb.fireStart = (stateQ == ST_HOLDSTART);
            strb.fireStop  = (stateQ == ST_HOLDSTOP);
            strb.clearCnt  = 1'b1;
            stateD         = ST_IDLE;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= stateD;
  end

  // R6
  scl_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && !stat.sclNow) |=> (stateQ == ST_IDLE));

  // R7
  sda_revert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLDSTART && stat.sdaNow) |=> (stateQ == ST_IDLE));

  // R8
  scl_low_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !stat.sclNow) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/i2c_cond_qual.sv
module i2c_cond_qual
  import i2c_cond_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int TICK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic             startDet,
  output logic             stopDet,
  output logic             busBusy
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  i2c_cond_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  i2c_cond_dp #(
    .CFG_W    (CFG_W),
    .TICK_DIV (TICK_DIV)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .sdaIn     (sdaIn),
    .sclIn     (sclIn),
    .strb      (strb),
    .stat      (stat),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .busBusy   (busBusy)
  );

endmodule

// File: tb/i2c_cond_qual_tb_top.sv
module i2c_cond_qual_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic       sdaIn = 1'b1;
  logic       sclIn = 1'b1;
  logic       startDet, stopDet, busBusy;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  i2c_cond_qual dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .sdaIn     (sdaIn),
    .sclIn     (sclIn),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .busBusy   (busBusy)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input string what, input int act,
                            input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // called at a negedge; returns edge count of first wanted pulse (0 if none)
  task automatic waitPulse(input bit wantStop, input int limit,
                           output int lat, output int otherCnt);
    lat = 0;
    otherCnt = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wantStop ? startDet : stopDet) otherCnt++;
      if ((wantStop ? stopDet : startDet) && lat == 0) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWrData = v;
    cfgWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idleEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // runs one condition and checks latency, width and busy
  task automatic runCond(input bit isStop, input int n, input string req);
    int lat, other;
    sdaIn = isStop ? 1'b1 : 1'b0;
    waitPulse(isStop, 2 * n + 4, lat, other);
    checkRange(req, isStop ? "stop latency" : "start latency", lat, 2 * n, 2 * n + 1);
    checkEq("R11", "opposite pulse", other, 0);
    checkEq("R9", "busy with pulse", int'(busBusy), isStop ? 0 : 1);
    @(posedge clk);
    @(negedge clk);
    checkEq(isStop ? "R3" : "R2", "pulse width", int'(isStop ? stopDet : startDet), 0);
  endtask

  task automatic tReset();
    checkEq("R1", "startDet after reset", int'(startDet), 0);
    checkEq("R1", "stopDet after reset", int'(stopDet), 0);
    checkEq("R1", "busBusy after reset", int'(busBusy), 0);
    runCond(1'b0, 1, "R1");
    runCond(1'b1, 1, "R1");
  endtask

  task automatic tBasic();
    writeCfg(8'h80);
    runCond(1'b0, 1, "R2");
    runCond(1'b1, 1, "R3");
    writeCfg(8'h8B);
    runCond(1'b0, 12, "R4");
    runCond(1'b1, 12, "R4");
    writeCfg(8'hFF);
    runCond(1'b0, 128, "R4");
    runCond(1'b1, 128, "R4");
  endtask

  task automatic tDisabled();
    writeCfg(8'h7F);
    runCond(1'b0, 1, "R5");
    runCond(1'b1, 1, "R5");
  endtask

  task automatic tSclAbort();
    int lat, other;
    writeCfg(8'h83);
    sdaIn = 1'b0;
    idleEdges(3);
    sclIn = 1'b0;
    waitPulse(1'b0, 20, lat, other);
    checkEq("R6", "startDet after scl drop", lat, 0);
    checkEq("R6", "busy after scl drop", int'(busBusy), 0);
    sdaIn = 1'b1;
    idleEdges(2);
    sclIn = 1'b1;
    idleEdges(4);
    runCond(1'b0, 4, "R6");
    runCond(1'b1, 4, "R6");
  endtask

  task automatic tSdaRevert();
    int lat, other;
    writeCfg(8'h83);
    sdaIn = 1'b0;
    idleEdges(3);
    sdaIn = 1'b1;
    waitPulse(1'b0, 20, lat, other);
    checkEq("R7", "startDet after revert", lat, 0);
    checkEq("R7", "stopDet after revert", other, 0);
    checkEq("R7", "busy after revert", int'(busBusy), 0);
    runCond(1'b0, 4, "R7");
  endtask

  task automatic tSclLow();
    int lat, other;
    // bus busy, SDA low, SCL high here
    sclIn = 1'b0;
    idleEdges(2);
    for (int k = 0; k < 6; k++) begin
      sdaIn = ~sdaIn;
      idleEdges(3);
    end
    sdaIn = 1'b1;
    idleEdges(2);
    sclIn = 1'b1;
    waitPulse(1'b0, 20, lat, other);
    checkEq("R8", "startDet with scl low", lat, 0);
    checkEq("R8", "stopDet with scl low", other, 0);
    checkEq("R8", "busy unchanged", int'(busBusy), 1);
    // repeated start keeps busy
    runCond(1'b0, 4, "R9");
    runCond(1'b1, 4, "R9");
  endtask

  task automatic tMidWrite();
    int lat, other;
    writeCfg(8'h83);
    sdaIn = 1'b0;
    idleEdges(1);
    cfgWrData = 8'hFF;
    cfgWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    checkEq("R10", "no early start", int'(startDet), 0);
    waitPulse(1'b0, 20, lat, other);
    checkRange("R10", "latency kept", lat + 2, 8, 9);
    runCond(1'b1, 128, "R10");
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tDisabled();
    tSclAbort();
    tSdaRevert();
    tSclLow();
    tMidWrite();
    idleEdges(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule